// File: doc/BRIEF.md
# Scrambled 64b/66b Block to Narrow Word Splitter

This block sits on the transmit side of a 64b/66b line path, between an upstream source of 66-bit blocks and a serdes whose parallel interface is narrower than the block. Each accepted block has a 2-bit sync header and a 64-bit payload. The payload goes through the self-synchronous 64b/66b scrambler, while the header goes out unchanged. The scrambled payload then leaves as a run of 64/WORD_W consecutive words on the serdes side.

The header and its strobe go out beside the first word of each run only. The data strobe goes out with every word. A mode input bit-reverses each word within its own width and swaps the two header bits. This serves serdes that shift out the most significant bit first.

Upstream handshaking uses a valid/ready pair. A new block is taken only when the word now on the output is the last of its run, or when the output is idle. Blocks offered back to back therefore leave without gaps.

Top module: `scr_word_splitter`

## Requirements
- R1: In the first cycle after synchronous reset, out_data_valid and out_hdr_valid are 0, out_data and out_hdr are 0, and in_ready is 1. The scrambler state is all ones and no word is pending.
- R2: Each accepted block produces exactly 64/WORD_W words on consecutive cycles, each with out_data_valid = 1. The first word appears in the cycle after the accepting clock edge.
- R3: Word k of a run (k = 0 first) carries scrambled payload bits [k*WORD_W + WORD_W-1 : k*WORD_W], so the least significant slice goes out first.
- R4: out_hdr_valid is 1 only with word 0 of a run. On all other words, and while idle, out_hdr_valid is 0 and out_hdr is 0.
- R5: Scrambling runs over payload bit 0 upward. Each scrambled bit is the payload bit XOR state bit 38 XOR state bit 57 of the 58-bit state. That scrambled bit is then shifted into state bit 0, and the state carries over from one block to the next.
- R6: The sync header is not scrambled: with reversal off, out_hdr on word 0 equals the in_hdr value that was accepted.
- R7: While rev_en is 1, every output word is bit-reversed within WORD_W bits (bit i moves to WORD_W-1-i), and out_hdr on word 0 is {in_hdr[0], in_hdr[1]}. rev_en is sampled on the edge that loads each word.
- R8: in_ready is 1 exactly when no word of the current run remains to be loaded. in_valid while in_ready is 0 has no effect on the outputs.
- R9: With no run in progress, out_data_valid is 0 and out_data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Upstream block valid |
| in_ready | output | 1 | Splitter can take a block on this edge |
| in_hdr | input | 2 | Sync header of the offered block |
| in_payload | input | 64 | Unscrambled payload of the offered block |
| rev_en | input | 1 | Bit-reverse output words and swap header bits |
| out_data | output | WORD_W | Scrambled payload word |
| out_data_valid | output | 1 | Word strobe, high on every word |
| out_hdr | output | 2 | Sync header, first word only |
| out_hdr_valid | output | 1 | Header strobe, first word only |

## Verification
The bench builds the block with WORD_W = 16, so every run has four words. That size reaches everything at once: the index walk through interior words, the last-word handover of ready, and reversal over a width smaller than the block. Holding in_valid high through whole runs shows that offers are ignored while words are pending, and that blocks chain without a gap cycle. A behavioural scrambler in the bench carries its state across blocks. Known payloads (all zeros, all ones, alternating) next to random ones show the state and taps evolving as specified.

// File: rtl/scr_split_pkg.sv
package scr_split_pkg;

    localparam int BLK_W   = 64;
    localparam int HDR_W   = 2;
    localparam int SCR_W   = 58;
    localparam int TAP_LO  = 38;
    localparam int TAP_HI  = 57;

    typedef logic [BLK_W-1:0] blk_t;
    typedef logic [HDR_W-1:0] hdr_t;
    typedef logic [SCR_W-1:0] scr_t;

endpackage

// File: rtl/scr_split_lfsr.sv
// Self-synchronous scrambler over a whole block in one cycle, bit 0 first.
module scr_split_lfsr #(
    parameter int DATA_W  = 64,
    parameter int STATE_W = 58,
    parameter int TAP_A   = 38,
    parameter int TAP_B   = 57
) (
    input  logic [STATE_W-1:0] state_i,
    input  logic [DATA_W-1:0]  data_i,
    output logic [DATA_W-1:0]  data_o,
    output logic [STATE_W-1:0] state_o
);

    logic [STATE_W-1:0] walk;
    logic               fb;

    always_comb begin
        walk   = state_i;
        data_o = '0;
        fb     = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            fb        = data_i[i] ^ walk[TAP_A] ^ walk[TAP_B];
            data_o[i] = fb;
            walk      = {walk[STATE_W-2:0], fb};
        end
        state_o = walk;
    end

endmodule

// File: rtl/scr_split_wordsel.sv
// Picks one word out of the block and optionally mirrors it.
module scr_split_wordsel #(
    parameter int BLK_W  = 64,
    parameter int WORD_W = 16,
    parameter int IDX_W  = 2
) (
    input  logic [BLK_W-1:0]  blk_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              rev_i,
    output logic [WORD_W-1:0] word_o
);

    localparam int NWORDS = BLK_W / WORD_W;

    logic [WORD_W-1:0] raw;
    logic [WORD_W-1:0] mirrored;

    generate
        if (NWORDS == 1) begin : g_single
            assign raw = blk_i;
            logic unused_idx;
            assign unused_idx = ^idx_i;
        end else begin : g_multi
            logic [WORD_W-1:0] slices [NWORDS];
            for (genvar s = 0; s < NWORDS; s++) begin : g_slice
                assign slices[s] = blk_i[s*WORD_W +: WORD_W];
            end
            assign raw = slices[idx_i];
        end
    endgenerate

    generate
        for (genvar b = 0; b < WORD_W; b++) begin : g_mirror
            assign mirrored[b] = raw[WORD_W-1-b];
        end
    endgenerate

    assign word_o = rev_i ? mirrored : raw;

endmodule

// File: rtl/scr_split_seq.sv
// Run sequencer: decides which word loads next and when upstream may hand over.
module scr_split_seq #(
    parameter int NWORDS = 4,
    parameter int IDX_W  = 2
) (
    input  logic             pend_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic             in_valid_i,
    output logic             ready_o,
    output logic             accept_o,
    output logic             load_o,
    output logic             first_o,
    output logic [IDX_W-1:0] sel_o,
    output logic             pend_o,
    output logic [IDX_W-1:0] idx_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NWORDS - 1);

    always_comb begin
        ready_o  = !pend_i;
        accept_o = in_valid_i && !pend_i;
        load_o   = 1'b0;
        first_o  = 1'b0;
        sel_o    = '0;
        pend_o   = pend_i;
        idx_o    = idx_i;
        if (accept_o) begin
            load_o  = 1'b1;
            first_o = 1'b1;
            if (NWORDS > 1) begin
                pend_o = 1'b1;
                idx_o  = IDX_W'(1);
            end else begin
                pend_o = 1'b0;
                idx_o  = '0;
            end
        end else if (pend_i) begin
            load_o = 1'b1;
            sel_o  = idx_i;
            if (idx_i == LAST_IDX) begin
                pend_o = 1'b0;
                idx_o  = '0;
            end else begin
                idx_o = idx_i + IDX_W'(1);
            end
        end
    end

endmodule

// File: rtl/scr_word_splitter.sv
module scr_word_splitter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [1:0]        in_hdr,
    input  logic [63:0]       in_payload,
    input  logic              rev_en,
    output logic [WORD_W-1:0] out_data,
    output logic              out_data_valid,
    output logic [1:0]        out_hdr,
    output logic              out_hdr_valid
);

    import scr_split_pkg::*;

    localparam int NWORDS = BLK_W / WORD_W;
    localparam int IDX_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1;

    typedef struct packed {
        blk_t              blk;
        scr_t              scr;
        logic              pend;
        logic [IDX_W-1:0]  idx;
        logic [WORD_W-1:0] data;
        logic              dv;
        hdr_t              hdr;
        logic              hv;
    } state_t;

    state_t st_d, st_q;

    blk_t              scr_blk;
    scr_t              scr_next;
    blk_t              sel_blk;
    logic [WORD_W-1:0] sel_word;
    logic              accept, load, first;
    logic [IDX_W-1:0]  sel_idx, idx_next;
    logic              pend_next;

    scr_split_lfsr #(
        .DATA_W (BLK_W),
        .STATE_W(SCR_W),
        .TAP_A  (TAP_LO),
        .TAP_B  (TAP_HI)
    ) u_lfsr (
        .state_i(st_q.scr),
        .data_i (in_payload),
        .data_o (scr_blk),
        .state_o(scr_next)
    );

    scr_split_seq #(
        .NWORDS(NWORDS),
        .IDX_W (IDX_W)
    ) u_seq (
        .pend_i    (st_q.pend),
        .idx_i     (st_q.idx),
        .in_valid_i(in_valid),
        .ready_o   (in_ready),
        .accept_o  (accept),
        .load_o    (load),
        .first_o   (first),
        .sel_o     (sel_idx),
        .pend_o    (pend_next),
        .idx_o     (idx_next)
    );

    assign sel_blk = accept ? scr_blk : st_q.blk;

    scr_split_wordsel #(
        .BLK_W (BLK_W),
        .WORD_W(WORD_W),
        .IDX_W (IDX_W)
    ) u_sel (
        .blk_i (sel_blk),
        .idx_i (sel_idx),
        .rev_i (rev_en),
        .word_o(sel_word)
    );

    always_comb begin
        st_d      = st_q;
        st_d.pend = pend_next;
        st_d.idx  = idx_next;
        if (accept) begin
            st_d.blk = scr_blk;
            st_d.scr = scr_next;
        end
        if (load) begin
            st_d.data = sel_word;
            st_d.dv   = 1'b1;
            st_d.hv   = first;
            if (first) begin
                st_d.hdr = rev_en ? {in_hdr[0], in_hdr[1]} : in_hdr;
            end else begin
                st_d.hdr = '0;
            end
        end else begin
            st_d.data = '0;
            st_d.dv   = 1'b0;
            st_d.hv   = 1'b0;
            st_d.hdr  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= '0;
            st_q.scr  <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_data       = st_q.data;
    assign out_data_valid = st_q.dv;
    assign out_hdr        = st_q.hdr;
    assign out_hdr_valid  = st_q.hv;

endmodule

// File: rtl/scr_word_splitter_chk.sv
module scr_word_splitter_chk #(
    parameter int WORD_W = 16,
    parameter int NWORDS = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic [WORD_W-1:0] out_data,
    input logic              out_data_valid,
    input logic [1:0]        out_hdr,
    input logic              out_hdr_valid
);

    logic [3:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else if (out_hdr_valid) begin
            run_q <= 4'd1;
        end else if (out_data_valid) begin
            run_q <= run_q + 4'd1;
        end else begin
            run_q <= '0;
        end
    end

    assert_block_len_R2: assert property (@(posedge clk) disable iff (rst)
        (out_data_valid && !out_hdr_valid) |-> (run_q >= 4'd1 && 32'(run_q) < NWORDS));

    assert_run_start_R2: assert property (@(posedge clk) disable iff (rst)
        out_hdr_valid |-> (run_q == 4'd0 || 32'(run_q) == NWORDS));

    assert_hdr_with_data_R4: assert property (@(posedge clk) disable iff (rst)
        out_hdr_valid |-> out_data_valid);

    assert_hdr_zero_R4: assert property (@(posedge clk) disable iff (rst)
        !out_hdr_valid |-> (out_hdr == 2'b00));

    assert_accept_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_hdr_valid);

    assert_ignore_R8: assert property (@(posedge clk) disable iff (rst)
        !in_ready |=> (out_data_valid && !out_hdr_valid));

    assert_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !out_data_valid |-> (out_data == '0 && in_ready));

endmodule

bind scr_word_splitter scr_word_splitter_chk #(
    .WORD_W(WORD_W),
    .NWORDS(64 / WORD_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .out_data      (out_data),
    .out_data_valid(out_data_valid),
    .out_hdr       (out_hdr),
    .out_hdr_valid (out_hdr_valid)
);

// File: tb/scr_word_splitter_test.sv
`timescale 1ns/1ps
module scr_word_splitter_test;

    localparam int W = 16;
    localparam int N = 64 / W;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          rev = 1'b0;
    logic [1:0]    in_hdr = 2'b00;
    logic [63:0]   in_pl = '0;
    logic          in_ready;
    logic [W-1:0]  out_data;
    logic          out_dv;
    logic [1:0]    out_hdr;
    logic          out_hv;

    always #2.5 clk = ~clk;

    scr_word_splitter #(.WORD_W(W)) uut (
        .clk           (clk),
        .rst           (rst),
        .in_valid      (in_valid),
        .in_ready      (in_ready),
        .in_hdr        (in_hdr),
        .in_payload    (in_pl),
        .rev_en        (rev),
        .out_data      (out_data),
        .out_data_valid(out_dv),
        .out_hdr       (out_hdr),
        .out_hdr_valid (out_hv)
    );

    typedef struct {
        logic [W-1:0] d;
        logic [1:0]   h;
        bit           hv;
    } exp_t;

    exp_t        expq[$];
    logic [57:0] mstate;
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done  = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // behavioural scrambler per the bit equation of R5
    function automatic logic [63:0] scramble(input logic [63:0] p);
        logic [63:0] r;
        for (int i = 0; i < 64; i++) begin
            logic nb;
            nb = p[i] ^ mstate[38] ^ mstate[57];
            r[i] = nb;
            mstate = {mstate[56:0], nb};
        end
        return r;
    endfunction

    function automatic logic [W-1:0] flip(input logic [W-1:0] w);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) r[W-1-i] = w[i];
        return r;
    endfunction

    task automatic step(input bit v, input logic [1:0] h, input logic [63:0] p);
        bit accept;
        @(negedge clk);
        if (expq.size() == 0) begin
            chk("R9 idle data_valid", {63'd0, out_dv}, 64'd0);
            chk("R9 idle data", {{(64-W){1'b0}}, out_data}, 64'd0);
            chk("R4 idle header_valid", {63'd0, out_hv}, 64'd0);
        end else begin
            chk("R2 data_valid", {63'd0, out_dv}, 64'd1);
            chk(rev ? "R3 R5 R7 data" : "R3 R5 data",
                {{(64-W){1'b0}}, out_data}, {{(64-W){1'b0}}, expq[0].d});
            chk(rev ? "R4 R7 header" : "R4 R6 header", {62'd0, out_hdr}, {62'd0, expq[0].h});
            chk("R4 header_valid", {63'd0, out_hv}, {63'd0, expq[0].hv});
        end
        chk("R8 ready", {63'd0, in_ready}, {63'd0, expq.size() <= 1});
        in_valid = v;
        in_hdr   = h;
        in_pl    = p;
        accept   = v && (expq.size() <= 1);
        if (expq.size() > 0) void'(expq.pop_front());
        if (accept) begin
            logic [63:0] s;
            s = scramble(p);
            for (int k = 0; k < N; k++) begin
                exp_t e;
                e.d  = rev ? flip(s[k*W +: W]) : s[k*W +: W];
                e.hv = (k == 0);
                e.h  = (k == 0) ? (rev ? {h[0], h[1]} : h) : 2'b00;
                expq.push_back(e);
            end
        end
    endtask

    task automatic drain();
        for (int i = 0; i < N + 2; i++) step(1'b0, 2'b00, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst    = 1'b0;
        mstate = '1;
        // R1: reset state seen before any post-reset edge
        chk("R1 data_valid", {63'd0, out_dv}, 64'd0);
        chk("R1 header_valid", {63'd0, out_hv}, 64'd0);
        chk("R1 data", {{(64-W){1'b0}}, out_data}, 64'd0);
        chk("R1 header", {62'd0, out_hdr}, 64'd0);
        chk("R1 ready", {63'd0, in_ready}, 64'd1);

        // single block, then idle
        step(1'b1, 2'b01, 64'h0123_4567_89AB_CDEF);
        drain();

        // known payloads back to back (R5 state carry-over)
        for (int b = 0; b < 4; b++) begin
            logic [63:0] p;
            case (b)
                0: p = 64'd0;
                1: p = '1;
                2: p = 64'hAAAA_AAAA_5555_5555;
                default: p = 64'h8000_0000_0000_0001;
            endcase
            for (int c = 0; c < N; c++) step(1'b1, (b % 2 == 0) ? 2'b10 : 2'b01, p);
        end
        drain();

        // in_valid held high with changing payload: offers while busy are ignored (R8)
        for (int c = 0; c < 5 * N + 3; c++)
            step(1'b1, 2'(c), {$urandom, $urandom});
        drain();

        // gaps between blocks
        for (int b = 0; b < 3; b++) begin
            step(1'b1, 2'b10, {$urandom, $urandom});
            for (int c = 0; c < N + b; c++) step(1'b0, 2'b11, {$urandom, $urandom});
        end
        drain();

        // reversal mode (R7)
        rev = 1'b1;
        for (int c = 0; c < 4 * N; c++)
            step(1'b1, (c % 3 == 0) ? 2'b01 : 2'b10, {$urandom, $urandom});
        drain();
        rev = 1'b0;
        for (int c = 0; c < 2 * N; c++) step(1'b1, 2'b01, {$urandom, $urandom});
        drain();

        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule